// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block contains the hazard logic for a five-stage in-order integer pipeline. Each cycle it reads the register specifiers and control flags that the datapath holds in its four inter-stage registers. From them it produces three kinds of control. It sets a forwarding select for each of the two ALU operands of the instruction in execute. It raises a one-cycle hold when an instruction in decode needs the result of a load that is still in execute. It raises a pair of flush strobes when a branch in execute resolves taken.

All outputs are combinational functions of the current inputs, so the datapath can apply them at the next clock edge. The clock and reset inputs serve only the built-in property checks.

The register file writes in the first half of a cycle and reads in the second half. A value being written back is therefore already visible to the instruction in decode, and no decode-stage bypass is generated. Branches resolve in execute, so a taken branch discards the two younger instructions behind it.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the execute/memory register holds a write (`mem_wr`=1) whose destination equals an operand's source in execute, that operand's select is 2'b10 (take the execute/memory result).
- R2: When only the memory/write-back register holds a matching write (`wb_wr`=1), that operand's select is 2'b01 (take the write-back value).
- R3: A match in execute/memory wins over a match in memory/write-back. A stage with its write flag low never matches. With no match the select is 2'b00 (register file value), which is also the value with all inputs idle.
- R4: A source or destination specifier of register 0 never produces a forward and never produces a stall.
- R5: A load in execute (`ex_load`=1) whose destination `ex_rt` equals `id_rs` raises `pc_hold`, `ifid_hold` and `idex_bubble` together in the same cycle.
- R6: The decode instruction's `id_rt` takes part in the load-use compare only when `id_uses_rt`=1.
- R7: An instruction in execute that is not a load never causes a stall, even when its destination matches a decode source.
- R8: A write-back destination that matches a decode source causes neither a stall nor a forward.
- R9: `br_taken`=1 raises both `ifid_flush` and `idex_flush`. With `br_taken`=0 both stay low.
- R10: When a load-use stall and a taken branch occur in the same cycle, the flush is raised and all three hold/bubble outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_n | input | 1 | Active-low reset; disables the property checks |
| id_rs | input | REG_W | First source of the instruction in decode |
| id_rt | input | REG_W | Second source of the instruction in decode |
| id_uses_rt | input | 1 | Decode instruction actually reads `id_rt` |
| ex_rs | input | REG_W | First source of the instruction in execute (operand A) |
| ex_rt | input | REG_W | Second source in execute (operand B); destination when it is a load |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | REG_W | Destination held in execute/memory register |
| mem_wr | input | 1 | Execute/memory instruction writes a register |
| wb_dst | input | REG_W | Destination held in memory/write-back register |
| wb_wr | input | 1 | Memory/write-back instruction writes a register |
| br_taken | input | 1 | Branch in execute resolved taken |
| fwd_a | output | 2 | Operand A select: 00 regfile, 10 execute/memory, 01 write-back |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_flush | output | 1 | Turn the fetched instruction into a no-op |
| idex_flush | output | 1 | Turn the decoding instruction into a no-op |

## Verification
The bench targets the cases where both later stages write the same register. A unit with the priority reversed would feed the older, stale value to the ALU. It also drives register 0 as destination and as source. A unit without the zero guard would forward garbage or stall for no reason. Load-use is exercised on each source separately, with the second source both marked used and marked unused. A unit that compared `id_rt` every time would stall on immediate-form instructions. The bench also raises a taken branch together with a load-use hit. A unit that let the stall win would hold a wrong-path instruction in decode instead of flushing it.

// File: rtl/hfu_pkg.sv
package hfu_pkg;

   // Operand source selection for the execute-stage ALU inputs.
   typedef enum logic [1:0] {
      FWD_REGFILE = 2'b00,
      FWD_WB      = 2'b01,
      FWD_MEM     = 2'b10
   } fwd_sel_e;

   localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/hfu_operand_fwd.sv
module hfu_operand_fwd
   import hfu_pkg::*;
#(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wr,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wr,
   output fwd_sel_e         sel
);

   logic src_live;
   logic hit_mem;
   logic hit_wb;

   // Variant: either register 0 is a constant zero, or every index is real.
   generate
      if (ZERO_HARDWIRED) begin : g_zero_reg
         assign src_live = |src;
      end else begin : g_no_zero_reg
         assign src_live = 1'b1;
      end
   endgenerate

   assign hit_mem = src_live && mem_wr && (mem_dst == src);
   assign hit_wb  = src_live && wb_wr  && (wb_dst  == src);

   // Nearest producer first.
   always_comb begin
      if (hit_mem)     sel = FWD_MEM;
      else if (hit_wb) sel = FWD_WB;
      else             sel = FWD_REGFILE;
   end

   // R3: both stages match -> the younger result is chosen
   a_r3_mem_beats_wb : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && wb_wr && mem_dst == src && wb_dst == src && src != '0)
         |-> sel == FWD_MEM);

   // R3: no stage writing -> register file value
   a_r3_idle_regfile : assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr && !wb_wr) |-> sel == FWD_REGFILE);

   // R4: register 0 is never bypassed
   generate
      if (ZERO_HARDWIRED) begin : g_zero_chk
         a_r4_zero_src : assert property (@(posedge clk) disable iff (!rst_n)
            (src == '0) |-> sel == FWD_REGFILE);
      end
   endgenerate

endmodule

// File: rtl/hfu_load_use.sv
module hfu_load_use #(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic             id_uses_rt,
   input  logic             ex_load,
   input  logic [REG_W-1:0] ex_rt,
   output logic             load_hit
);

   logic dst_live;
   logic rs_match;
   logic rt_match;

   generate
      if (ZERO_HARDWIRED) begin : g_zero_reg
         assign dst_live = |ex_rt;
      end else begin : g_no_zero_reg
         assign dst_live = 1'b1;
      end
   endgenerate

   assign rs_match = (id_rs == ex_rt);
   assign rt_match = id_uses_rt && (id_rt == ex_rt);
   assign load_hit = ex_load && dst_live && (rs_match || rt_match);

   // R7: only a load in execute can cause a load-use hit
   a_r7_nonload_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !ex_load |-> !load_hit);

   // R6: an unread second source cannot create a hit on its own
   a_r6_rt_unused : assert property (@(posedge clk) disable iff (!rst_n)
      (!id_uses_rt && id_rs != ex_rt) |-> !load_hit);

endmodule

// File: rtl/hfu_flow_ctl.sv
module hfu_flow_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic load_hit,
   input  logic br_taken,
   output logic pc_hold,
   output logic ifid_hold,
   output logic idex_bubble,
   output logic ifid_flush,
   output logic idex_flush
);

   logic stall;

   // The redirect discards the stalled instruction anyway, so flush wins.
   assign stall       = load_hit && !br_taken;
   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;
   assign ifid_flush  = br_taken;
   assign idex_flush  = br_taken;

   // R10: a taken branch never coexists with a hold
   a_r10_flush_wins : assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> (!pc_hold && !ifid_hold && !idex_bubble));

   // R5: a hit without a redirect holds the front end
   a_r5_hit_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (load_hit && !br_taken) |-> (pc_hold && idex_bubble));

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
   import hfu_pkg::*;
#(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic             id_uses_rt,
   input  logic [REG_W-1:0] ex_rs,
   input  logic [REG_W-1:0] ex_rt,
   input  logic             ex_load,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wr,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wr,
   input  logic             br_taken,
   output logic [1:0]       fwd_a,
   output logic [1:0]       fwd_b,
   output logic             pc_hold,
   output logic             ifid_hold,
   output logic             idex_bubble,
   output logic             ifid_flush,
   output logic             idex_flush
);

   localparam int unsigned NREGS = 1 << REG_W;

   // Elaboration-time parameter checks
   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
         $fatal(1, "hazard_fwd_unit: REG_W must be 1..8");
      end
      if (ZERO_HARDWIRED && NREGS < 2) begin : g_bad_zero
         $fatal(1, "hazard_fwd_unit: register 0 needs at least two registers");
      end
   endgenerate

   logic [REG_W-1:0] opnd_src [NUM_OPERANDS];
   fwd_sel_e         opnd_sel [NUM_OPERANDS];
   logic             load_hit;

   assign opnd_src[0] = ex_rs;
   assign opnd_src[1] = ex_rt;

   generate
      for (genvar k = 0; k < NUM_OPERANDS; k++) begin : g_opnd
         hfu_operand_fwd #(
            .REG_W          (REG_W),
            .ZERO_HARDWIRED (ZERO_HARDWIRED)
         ) u_fwd (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (opnd_src[k]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr),
            .sel     (opnd_sel[k])
         );
      end
   endgenerate

   assign fwd_a = opnd_sel[0];
   assign fwd_b = opnd_sel[1];

   hfu_load_use #(
      .REG_W          (REG_W),
      .ZERO_HARDWIRED (ZERO_HARDWIRED)
   ) u_load_use (
      .clk        (clk),
      .rst_n      (rst_n),
      .id_rs      (id_rs),
      .id_rt      (id_rt),
      .id_uses_rt (id_uses_rt),
      .ex_load    (ex_load),
      .ex_rt      (ex_rt),
      .load_hit   (load_hit)
   );

   hfu_flow_ctl u_flow (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_hit    (load_hit),
      .br_taken    (br_taken),
      .pc_hold     (pc_hold),
      .ifid_hold   (ifid_hold),
      .idex_bubble (idex_bubble),
      .ifid_flush  (ifid_flush),
      .idex_flush  (idex_flush)
   );

   // R9: flush strobes follow the branch outcome exactly
   a_r9_flush_follows : assert property (@(posedge clk) disable iff (!rst_n)
      (ifid_flush == br_taken) && (idex_flush == br_taken));

   // R8/R7: write-back activity alone never stalls decode
   a_r8_wb_no_stall : assert property (@(posedge clk) disable iff (!rst_n)
      !ex_load |-> !pc_hold);

   // R5: the three hold controls move together
   a_r5_hold_together : assert property (@(posedge clk) disable iff (!rst_n)
      (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));

   // R1: a legal select code only
   a_r1_sel_legal : assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != 2'b11) && (fwd_b != 2'b11));

endmodule

// File: tb/hazard_fwd_unit_test.sv
module hazard_fwd_unit_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] id_rs, id_rt, ex_rs, ex_rt, mem_dst, wb_dst;
   logic       id_uses_rt, ex_load, mem_wr, wb_wr, br_taken;
   logic [1:0] fwd_a, fwd_b;
   logic       pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   hazard_fwd_unit uut (
      .clk(clk), .rst_n(rst_n),
      .id_rs(id_rs), .id_rt(id_rt), .id_uses_rt(id_uses_rt),
      .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_load(ex_load),
      .mem_dst(mem_dst), .mem_wr(mem_wr),
      .wb_dst(wb_dst), .wb_wr(wb_wr), .br_taken(br_taken),
      .fwd_a(fwd_a), .fwd_b(fwd_b),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
      .ifid_flush(ifid_flush), .idex_flush(idex_flush)
   );

   typedef struct packed {
      logic [4:0] rs_d;  logic [4:0] rt_d;  logic use_rt;
      logic [4:0] rs_x;  logic [4:0] rt_x;  logic ld;
      logic [4:0] dst_m; logic wr_m;
      logic [4:0] dst_w; logic wr_w;
      logic       br;
      logic [1:0] exp_a; logic [1:0] exp_b; logic exp_stall; logic exp_flush;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      //  rsD rtD u  rsX rtX ld dM wM dW wW br  a      b     st fl  req
      '{ 0,  0, 0,  3,  4, 0, 3, 1, 0, 0, 0, 2'b10, 2'b00, 0, 0, 1 },  // R1 A from EX/MEM
      '{ 0,  0, 0,  3,  4, 0, 4, 1, 0, 0, 0, 2'b00, 2'b10, 0, 0, 1 },  // R1 B from EX/MEM
      '{ 0,  0, 0,  3,  4, 0, 0, 0, 4, 1, 0, 2'b00, 2'b01, 0, 0, 2 },  // R2 B from MEM/WB
      '{ 0,  0, 0,  6,  4, 0, 0, 0, 6, 1, 0, 2'b01, 2'b00, 0, 0, 2 },  // R2 A from MEM/WB
      '{ 0,  0, 0,  5,  5, 0, 5, 1, 5, 1, 0, 2'b10, 2'b10, 0, 0, 3 },  // R3 priority
      '{ 0,  0, 0,  5,  2, 0, 5, 0, 5, 1, 0, 2'b01, 2'b00, 0, 0, 3 },  // R3 wr gate
      '{ 0,  0, 0,  5,  2, 0, 5, 0, 2, 0, 0, 2'b00, 2'b00, 0, 0, 3 },  // R3 none
      '{ 0,  0, 0,  0,  0, 0, 0, 1, 0, 1, 0, 2'b00, 2'b00, 0, 0, 4 },  // R4 zero fwd
      '{ 0,  8, 1,  1,  0, 1, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 4 },  // R4 zero load
      '{ 7,  8, 1,  1,  7, 1, 0, 0, 0, 0, 0, 2'b00, 2'b00, 1, 0, 5 },  // R5 rs load-use
      '{ 2,  7, 1,  1,  7, 1, 0, 0, 0, 0, 0, 2'b00, 2'b00, 1, 0, 6 },  // R6 rt used
      '{ 2,  7, 0,  1,  7, 1, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 6 },  // R6 rt unused
      '{ 7,  7, 1,  1,  7, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 7 },  // R7 non-load
      '{ 9,  9, 1,  1,  2, 0, 0, 0, 9, 1, 0, 2'b00, 2'b00, 0, 0, 8 },  // R8 wb vs decode
      '{ 0,  0, 0,  1,  2, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, 1, 9 },  // R9 taken
      '{ 7,  0, 0,  1,  7, 1, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, 1, 10 }  // R10 flush wins
   };

   task automatic drive(input vec_t v);
      id_rs = v.rs_d; id_rt = v.rt_d; id_uses_rt = v.use_rt;
      ex_rs = v.rs_x; ex_rt = v.rt_x; ex_load = v.ld;
      mem_dst = v.dst_m; mem_wr = v.wr_m;
      wb_dst = v.dst_w; wb_wr = v.wr_w; br_taken = v.br;
   endtask

   task automatic check(input int req, input logic [1:0] ea, input logic [1:0] eb,
                        input logic es, input logic ef);
      total++;
      if (fwd_a !== ea || fwd_b !== eb ||
          {pc_hold, ifid_hold, idex_bubble} !== {3{es}} ||
          {ifid_flush, idex_flush} !== {2{ef}}) begin
         bad++;
         $display("FAIL R%0d: got a=%b b=%b hold=%b%b%b flush=%b%b exp a=%b b=%b stall=%b flush=%b",
                  req, fwd_a, fwd_b, pc_hold, ifid_hold, idex_bubble,
                  ifid_flush, idex_flush, ea, eb, es, ef);
      end
   endtask

   initial begin
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      drive('0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(3, 2'b00, 2'b00, 1'b0, 1'b0);  // R3 idle/reset state
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         #2;
         check(int'(VECS[i].req), VECS[i].exp_a, VECS[i].exp_b,
               VECS[i].exp_stall, VECS[i].exp_flush);
      end

      // R9 not taken after a taken cycle: flushes drop
      @(negedge clk);
      drive('0);
      ex_rs = 5'd3; mem_dst = 5'd3; mem_wr = 1'b1;
      #2;
      check(9, 2'b10, 2'b00, 1'b0, 1'b0);

      // R5 stall with rt also matching and forwarding on A at once
      @(negedge clk);
      drive('0);
      id_rs = 5'd12; id_rt = 5'd12; id_uses_rt = 1'b1;
      ex_rs = 5'd4; ex_rt = 5'd12; ex_load = 1'b1;
      wb_dst = 5'd4; wb_wr = 1'b1;
      #2;
      check(5, 2'b01, 2'b00, 1'b1, 1'b0);

      // R4 highest register index still forwards normally
      @(negedge clk);
      drive('0);
      ex_rs = 5'd31; ex_rt = 5'd31; mem_dst = 5'd31; mem_wr = 1'b1;
      #2;
      check(4, 2'b10, 2'b10, 1'b0, 1'b0);

      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule